// File: doc/BRIEF.md
# Match Compare Timer

This block is an up-counting timer with a programmable compare value. It sits behind a plain single-cycle register bus: address, write strobe, write data and combinational read data. Software loads a compare value, picks a tick prescale, and sets a run bit. The counter then advances once per prescaled tick. When the count reaches the compare value, the block sends a one-clock interrupt pulse.

Two modes are available. In one-shot mode the counter keeps going past the compare value. To re-arm, software clears the count, reloads the compare value and sets the run bit again. In periodic mode the clear-on-match bit is set, and the count falls back to zero on the tick after it equals the compare value. This yields a steady train of pulses. Any write to the clear location zeroes the count at once and restarts the prescale phase.

Top module: `cmp_tick_timer`

## Requirements
- R1: After reset the compare register reads all-ones, the control register reads 0, the count reads 0, the divider reads 0 and the interrupt output is low.
- R2: The word offsets are 0x00 compare, 0x04 count (read only), 0x08 control (bit 0 run, bit 1 clear-on-match), 0x0C clear (write only) and 0x34 divider (bits [1:0]). Compare reads back the last written value. Control and divider read back their written bits with zeros above. The clear offset and every unmapped offset read zero.
- R3: While the run bit is 0 the count holds its value.
- R4: With divider value v, the count read n clock cycles after the write that sets the run bit equals floor(n/(v+1)).
- R5: A write of any data to the clear offset makes the count 0 after that clock edge and restarts the prescale phase. From then on the count n cycles later is floor(n/(v+1)).
- R6: The counter wraps from its all-ones value to zero and keeps counting.
- R7: With the run bit set, a compare value m and divider v, the interrupt rises 1 cycle after the count first equals m. That is m*(v+1)+1 cycles after the run-setting write. It stays high for exactly one cycle and does not fire again while the count stays equal.
- R8: With clear-on-match set and m of at least 1, the count returns to 0 on the tick after it equals m. Interrupts then repeat every (m+1)*(v+1) cycles.
- R9: A compare distance of 4 ticks, counted from a cleared count, produces exactly one interrupt at the time R7 gives.
- R10: With clear-on-match clear, the count continues past the compare value after the interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| irq_o | output | 1 | One-cycle interrupt pulse on a compare hit |

## Verification
A write takes effect at the clock edge that samples the strobe. Read data is combinational, so the bench reads a register a moment after the falling edge that follows, and no latency is added. Every count check counts the rising edges since the write that set the run bit or cleared the count, and compares against floor(n/(v+1)). The interrupt passes through one register after the compare hit, so the bench compares irq_o at every falling edge of a window with the one cycle that R7 and R8 predict. A second instance with an 8-bit counter makes the wrap reachable in a few hundred cycles.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

   // Register offsets (byte addresses, word aligned)
   localparam int unsigned OFS_MATCH = 32'h00;
   localparam int unsigned OFS_COUNT = 32'h04;
   localparam int unsigned OFS_CTRL  = 32'h08;
   localparam int unsigned OFS_CLEAR = 32'h0C;
   localparam int unsigned OFS_DIV   = 32'h34;

   // Highest offset decoded, used to size the address bus check
   localparam int unsigned OFS_TOP   = OFS_DIV;

   // Control register layout: bit 0 run, bit 1 clear-on-match
   typedef struct packed {
      logic clr_on_match;
      logic run;
   } ctrl_t;

   localparam int unsigned CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs
   import cmp_timer_pkg::*;
#(
   parameter int unsigned ADDR_W        = 8,
   parameter int unsigned DATA_W        = 32,
   parameter int unsigned CNT_W         = 32,
   parameter int unsigned DIV_W         = 2,
   parameter bit          USE_PRESCALER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [CNT_W-1:0]  cnt_i,
   output logic [CNT_W-1:0]  match_o,
   output ctrl_t             ctrl_o,
   output logic [DIV_W-1:0]  div_o,
   output logic              clear_o,
   output logic [DATA_W-1:0] rdata_o
);

   localparam logic [ADDR_W-1:0] A_MATCH = ADDR_W'(OFS_MATCH);
   localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFS_COUNT);
   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_CLEAR = ADDR_W'(OFS_CLEAR);
   localparam logic [ADDR_W-1:0] A_DIV   = ADDR_W'(OFS_DIV);

   logic              sel_match;
   logic              sel_ctrl;
   logic              sel_clear;
   logic              sel_div;
   logic [CNT_W-1:0]  match_q;
   ctrl_t             ctrl_q;
   logic [DIV_W-1:0]  div_q;

   assign sel_match = (bus_addr == A_MATCH);
   assign sel_ctrl  = (bus_addr == A_CTRL);
   assign sel_clear = (bus_addr == A_CLEAR);
   assign sel_div   = (bus_addr == A_DIV);

   // Compare register, idles at all-ones
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_q <= '1;
      end else if (bus_wr && sel_match) begin
         match_q <= bus_wdata[CNT_W-1:0];
      end
   end

   // Control register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (bus_wr && sel_ctrl) begin
         ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      end
   end

   // Divider register, present only when the prescaler is built
   generate
      if (USE_PRESCALER) begin : g_div_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               div_q <= '0;
            end else if (bus_wr && sel_div) begin
               div_q <= bus_wdata[DIV_W-1:0];
            end
         end
      end else begin : g_div_none
         assign div_q = '0;
      end
   endgenerate

   // Clear is a strobe only, nothing is stored
   assign clear_o = bus_wr && sel_clear;

   // Read path, zero extended
   always_comb begin
      rdata_o = '0;
      case (bus_addr)
         A_MATCH: rdata_o[CNT_W-1:0]  = match_q;
         A_COUNT: rdata_o[CNT_W-1:0]  = cnt_i;
         A_CTRL:  rdata_o[CTRL_W-1:0] = ctrl_q;
         A_DIV:   rdata_o[DIV_W-1:0]  = div_q;
         default: rdata_o = '0;
      endcase
   end

   // Upper write-data bits beyond the stored fields are dropped
   logic unused_wdata;
   assign unused_wdata = ^bus_wdata;

   assign match_o = match_q;
   assign ctrl_o  = ctrl_q;
   assign div_o   = div_q;

   AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && sel_ctrl) |=> $stable(ctrl_o)); // R2

   AST_MATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && sel_match) |=> $stable(match_o)); // R2

   AST_MATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && sel_match) |=> (match_o == $past(bus_wdata[CNT_W-1:0]))); // R2

endmodule

// File: rtl/cmp_timer_prescale.sv
module cmp_timer_prescale #(
   parameter int unsigned DIV_W         = 2,
   parameter bit          USE_PRESCALER = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             restart_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);

   generate
      if (USE_PRESCALER) begin : g_div
         logic [DIV_W-1:0] phase_q;
         logic             tick;

         // Greater-or-equal keeps a shrinking divider from stalling the phase
         assign tick = run_i && (phase_q >= div_i);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               phase_q <= '0;
            end else if (!run_i || restart_i || tick) begin
               phase_q <= '0;
            end else begin
               phase_q <= phase_q + 1'b1;
            end
         end

         assign tick_o = tick;

         AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
            (tick_o && (div_i != '0)) |=> (!tick_o || (div_i == '0))); // R4

      end else begin : g_nodiv
         logic unused_inputs;
         assign unused_inputs = ^{clk, rst_n, restart_i, div_i};
         assign tick_o        = run_i;
      end
   endgenerate

   AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |-> run_i); // R3

endmodule

// File: rtl/cmp_timer_core.sv
module cmp_timer_core #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             clear_i,
   input  logic             run_i,
   input  logic             clr_on_match_i,
   input  logic [CNT_W-1:0] match_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             irq_o
);

   logic [CNT_W-1:0] cnt_q;
   logic             at_match;
   logic             hit;
   logic             hit_seen_q;
   logic             irq_q;

   assign at_match = (cnt_q == match_i);
   assign hit      = run_i && at_match;

   // Counter: clear write wins over any tick in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear_i) begin
         cnt_q <= '0;
      end else if (tick_i) begin
         if (clr_on_match_i && at_match) begin
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // Interrupt: rising edge of the hit condition, registered
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_seen_q <= 1'b0;
         irq_q      <= 1'b0;
      end else begin
         hit_seen_q <= hit;
         irq_q      <= hit && !hit_seen_q;
      end
   end

   assign cnt_o = cnt_q;
   assign irq_o = irq_q;

   AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o); // R7

   AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && !clear_i) |=> $stable(cnt_o)); // R3

   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (cnt_o == '0)); // R5

   AST_COM_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && clr_on_match_i && (cnt_o == match_i)) |=> (cnt_o == '0)); // R8

   AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !clear_i) |=> $stable(cnt_o)); // R4

endmodule

// File: rtl/cmp_tick_timer.sv
module cmp_tick_timer
   import cmp_timer_pkg::*;
#(
   parameter int unsigned ADDR_W        = 8,
   parameter int unsigned DATA_W        = 32,
   parameter int unsigned CNT_W         = 32,
   parameter int unsigned DIV_W         = 2,
   parameter bit          USE_PRESCALER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o
);

   localparam int unsigned ADDR_MIN = $clog2(OFS_TOP + 1);

   // Elaboration-time parameter checks
   generate
      if (ADDR_W < ADDR_MIN) begin : g_bad_addr
         $error("cmp_tick_timer: ADDR_W too small for the register map");
      end
      if (CNT_W > DATA_W || CNT_W < 2) begin : g_bad_cnt
         $error("cmp_tick_timer: CNT_W must lie in 2..DATA_W");
      end
      if (DIV_W < 1 || DIV_W > DATA_W) begin : g_bad_div
         $error("cmp_tick_timer: DIV_W must lie in 1..DATA_W");
      end
      if (DATA_W < CTRL_W) begin : g_bad_data
         $error("cmp_tick_timer: DATA_W cannot hold the control field");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] match;
   ctrl_t            ctrl;
   logic [DIV_W-1:0] div;
   logic             clear;
   logic             tick;

   cmp_timer_regs #(
      .ADDR_W        (ADDR_W),
      .DATA_W        (DATA_W),
      .CNT_W         (CNT_W),
      .DIV_W         (DIV_W),
      .USE_PRESCALER (USE_PRESCALER)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .cnt_i     (cnt),
      .match_o   (match),
      .ctrl_o    (ctrl),
      .div_o     (div),
      .clear_o   (clear),
      .rdata_o   (bus_rdata)
   );

   cmp_timer_prescale #(
      .DIV_W         (DIV_W),
      .USE_PRESCALER (USE_PRESCALER)
   ) u_prescale (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (ctrl.run),
      .restart_i (clear),
      .div_i     (div),
      .tick_o    (tick)
   );

   cmp_timer_core #(
      .CNT_W (CNT_W)
   ) u_core (
      .clk            (clk),
      .rst_n          (rst_n),
      .tick_i         (tick),
      .clear_i        (clear),
      .run_i          (ctrl.run),
      .clr_on_match_i (ctrl.clr_on_match),
      .match_i        (match),
      .cnt_o          (cnt),
      .irq_o          (irq_o)
   );

endmodule

// File: tb/cmp_tick_timer_bench.sv
module cmp_tick_timer_bench;

   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] A_MATCH = 8'h00;
   localparam logic [7:0] A_COUNT = 8'h04;
   localparam logic [7:0] A_CTRL  = 8'h08;
   localparam logic [7:0] A_CLEAR = 8'h0C;
   localparam logic [7:0] A_DIV   = 8'h34;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  a_addr = '0;
   logic        a_wr = 1'b0;
   logic [31:0] a_wdata = '0;
   logic [31:0] a_rdata;
   logic        a_irq;
   logic [7:0]  n_addr = '0;
   logic        n_wr = 1'b0;
   logic [31:0] n_wdata = '0;
   logic [31:0] n_rdata;
   logic        n_irq;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cmp_tick_timer u_cmp_tick_timer (
      .clk (clk), .rst_n (rst_n), .bus_addr (a_addr), .bus_wr (a_wr),
      .bus_wdata (a_wdata), .bus_rdata (a_rdata), .irq_o (a_irq)
   );

   // Narrow counter so that the wrap is reachable
   cmp_tick_timer #(.CNT_W (8)) u_cmp_tick_timer_narrow (
      .clk (clk), .rst_n (rst_n), .bus_addr (n_addr), .bus_wr (n_wr),
      .bus_wdata (n_wdata), .bus_rdata (n_rdata), .irq_o (n_irq)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // Drive at a falling edge, return at the next falling edge
   task automatic wr(input bit nar, input logic [7:0] a, input logic [31:0] d);
      if (nar) begin n_addr = a; n_wdata = d; n_wr = 1'b1; end
      else     begin a_addr = a; a_wdata = d; a_wr = 1'b1; end
      @(negedge clk);
      n_wr = 1'b0;
      a_wr = 1'b0;
   endtask

   task automatic rd(input bit nar, input logic [7:0] a, output logic [31:0] d);
      if (nar) begin n_addr = a; #1; d = n_rdata; end
      else     begin a_addr = a; #1; d = a_rdata; end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic int exp_count(input int n, input int d);
      return n / (d + 1);
   endfunction

   function automatic bit exp_irq(input int k, input int m, input int d, input bit com);
      int first;
      first = m * (d + 1) + 1;
      if (k < first) return 1'b0;
      if (!com) return (k == first);
      return ((k - first) % ((m + 1) * (d + 1))) == 0;
   endfunction

   // Arm the timer and compare irq_o each cycle of a window
   task automatic irq_window(input int m, input int d, input bit com, input string req);
      int w;
      logic [31:0] v;
      wr(0, A_CTRL, 32'h0);
      wr(0, A_DIV, d);
      wr(0, A_CLEAR, $urandom);
      wr(0, A_MATCH, m);
      wr(0, A_CTRL, {30'h0, com, 1'b1});
      w = com ? (m * (d + 1) + 3 * (m + 1) * (d + 1) + 2) : (m * (d + 1) + 10);
      for (int k = 1; k <= w; k++) begin
         @(negedge clk);
         check(a_irq == exp_irq(k, m, d, com), req, a_irq, exp_irq(k, m, d, com));
      end
      if (!com) begin
         rd(0, A_COUNT, v);
         check(v == exp_count(w, d), "R10", v, exp_count(w, d)); // R10 count runs past match
      end
   endtask

   initial begin
      logic [31:0] v;
      logic [31:0] d;
      logic [31:0] held;
      int dv, n, m;
      void'($urandom(32'd5150));

      idle(3);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(0, A_MATCH, v); check(v == 32'hFFFF_FFFF, "R1", v, 32'hFFFF_FFFF);
      rd(0, A_CTRL,  v); check(v == 0, "R1", v, 0);
      rd(0, A_COUNT, v); check(v == 0, "R1", v, 0);
      rd(0, A_DIV,   v); check(v == 0, "R1", v, 0);
      check(a_irq == 1'b0, "R1", a_irq, 0);

      // R2 register readback, random data
      for (int i = 0; i < 20; i++) begin
         d = $urandom;
         wr(0, A_MATCH, d); rd(0, A_MATCH, v); check(v == d, "R2", v, d);
         d = $urandom;
         wr(0, A_CTRL, d); rd(0, A_CTRL, v); check(v == (d & 32'h3), "R2", v, d & 32'h3);
         d = $urandom;
         wr(0, A_DIV, d); rd(0, A_DIV, v); check(v == (d & 32'h3), "R2", v, d & 32'h3);
         rd(0, A_CLEAR, v); check(v == 0, "R2", v, 0);
         begin
            logic [7:0] ua;
            ua = 8'(($urandom % 64) * 4);
            if (ua != A_MATCH && ua != A_COUNT && ua != A_CTRL && ua != A_DIV) begin
               rd(0, ua, v); check(v == 0, "R2", v, 0);
            end
         end
      end
      wr(0, A_CTRL, 32'h0);
      wr(0, A_MATCH, 32'hFFFF_FFFF);

      // R3 stopped counter holds
      wr(0, A_DIV, 0);
      wr(0, A_CLEAR, 0);
      idle(10);
      rd(0, A_COUNT, v); check(v == 0, "R3", v, 0);
      wr(0, A_CTRL, 32'h1);
      idle(6);
      wr(0, A_CTRL, 32'h0);           // 7 edges with run set, the last included
      rd(0, A_COUNT, held); check(held == 7, "R3", held, 7);
      idle(12);
      rd(0, A_COUNT, v); check(v == held, "R3", v, held);

      // R4 prescaled counting, random divider and duration
      for (int i = 0; i < 12; i++) begin
         dv = $urandom % 4;
         n  = 1 + $urandom % 40;
         wr(0, A_CTRL, 0);
         wr(0, A_DIV, dv);
         wr(0, A_CLEAR, $urandom);
         wr(0, A_CTRL, 32'h1);
         idle(n);
         rd(0, A_COUNT, v);
         check(v == exp_count(n, dv), "R4", v, exp_count(n, dv));
      end

      // R5 clear while running, any data
      for (int i = 0; i < 6; i++) begin
         dv = $urandom % 4;
         wr(0, A_CTRL, 0);
         wr(0, A_DIV, dv);
         wr(0, A_CTRL, 32'h1);
         idle(5 + $urandom % 20);
         wr(0, A_CLEAR, $urandom);
         rd(0, A_COUNT, v); check(v == 0, "R5", v, 0);
         n = 1 + $urandom % 30;
         idle(n);
         rd(0, A_COUNT, v); check(v == exp_count(n, dv), "R5", v, exp_count(n, dv));
      end
      wr(0, A_CTRL, 0);

      // R6 wrap on the 8-bit instance
      wr(1, A_DIV, 0);
      wr(1, A_CLEAR, 0);
      wr(1, A_CTRL, 32'h1);
      idle(256);
      rd(1, A_COUNT, v); check(v == 0, "R6", v, 0);
      idle(44);
      rd(1, A_COUNT, v); check(v == 44, "R6", v, 44);

      // R9 directed minimum distance of four ticks
      irq_window(4, 0, 1'b0, "R9");
      irq_window(4, 3, 1'b0, "R9");

      // R7 one-shot pulses, directed corners then random
      irq_window(0, 0, 1'b0, "R7");
      irq_window(1, 2, 1'b0, "R7");
      for (int i = 0; i < 5; i++) begin
         m  = $urandom % 9;
         dv = $urandom % 4;
         irq_window(m, dv, 1'b0, "R7");
      end

      // R8 periodic restart
      irq_window(1, 0, 1'b1, "R8");
      for (int i = 0; i < 5; i++) begin
         m  = 1 + $urandom % 6;
         dv = $urandom % 4;
         irq_window(m, dv, 1'b1, "R8");
      end

      done = 1'b1;
      report();
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         report();
      end
   end

endmodule